// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Controller

This block runs an 18-bit successive-approximation converter over a three-wire serial link and turns each conversion into a parallel word for the host. A single line both starts the conversion and selects the converter. The controller raises that line for the whole conversion window and then lowers it so the converter drives its serial output. It then sends 18 short serial clock pulses and shifts the result in, most significant bit first. All timing is counted in cycles of a 100 MHz system clock.

The host either pulses a start request for a single sample or holds a run enable for continuous sampling. A host-supplied period sets the minimum spacing between conversion starts. The block never lets that spacing drop below the converter's own minimum cycle time. Each finished word is presented together with a one-cycle valid pulse. A parameter selects the fast or the slow converter variant. Every duration is a parameter in system-clock counts. The defaults are 150 or 950 cycles of conversion and a 200 or 1000 cycle minimum cycle period.

Top module: `sar_readout`

## Requirements
- R1: While reset is held, and right after it is released, the convert line, the serial clock and the valid pulse are low and the sample word is zero.
- R2: A request sampled in idle, with the spacing window expired, raises the convert line on the next cycle. The line stays high for exactly max(conversion count, minimum pulse count) cycles. Requests that arrive while a conversion or readout is in progress are ignored.
- R3: After the convert line falls, the first serial clock rising edge comes exactly EN_WAIT + SCK_PERIOD - 1 cycles later. That is never sooner than EN_WAIT cycles.
- R4: Each readout has exactly 18 serial clock pulses. Each pulse is high for one cycle, and consecutive rising edges are SCK_PERIOD cycles apart.
- R5: The serial clock is low while idle and whenever the convert line is high.
- R6: The sample word holds the data line value captured at each serial clock rising edge. The first captured bit lands in bit 17 and the last in bit 0.
- R7: The valid output is high for one cycle only. That cycle follows the 18th serial clock falling edge, and the new word appears in that same cycle.
- R8: Two consecutive conversion starts are at least max(host period, minimum cycle period) cycles apart, using the period in force at the earlier start. A request made inside that window has no effect.
- R9: With run enable held high, conversions repeat on their own. The start spacing is exactly the largest of the host period, the minimum cycle period and the readout length (conversion hold + EN_WAIT + 18 * SCK_PERIOD + 1 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz) |
| rstN | input | 1 | Synchronous reset, active low |
| startReq | input | 1 | Single-sample request |
| runEn | input | 1 | Continuous sampling enable |
| periodCfg | input | PERIOD_W | Host start-to-start period in system cycles |
| adcSdo | input | 1 | Serial data from the converter |
| adcCnv | output | 1 | Convert strobe, also the converter select |
| adcSck | output | 1 | Serial clock to the converter |
| sample | output | BITS | Last assembled sample |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench builds the fast variant with its conversion count shortened to 20 cycles, its minimum cycle period to 120 cycles and its minimum pulse to 12 cycles. The readout then takes 97 cycles, shorter than the minimum period, so the spacing guard against early requests and the period floor both come into play within a few hundred cycles. Host periods of 0, 150 and 200 cover the cases where the floor wins and where the host value wins. The bench's own converter model returns timed serial data, including all-ones, all-zeros and single-bit edge patterns.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT
  } sarState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;    // a new conversion was accepted
    logic capture;  // sample the data line (serial clock rises)
    logic emit;     // last bit done, publish the word
  } sarStrobe_t;

endpackage

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_readout_pkg::*;
#(
  parameter int BITS       = 18,
  parameter int CNV_HOLD   = 150,
  parameter int EN_WAIT    = 4,
  parameter int SCK_PERIOD = 4,
  parameter int MIN_PERIOD = 200,
  parameter int PERIOD_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                runEn,
  input  logic [PERIOD_W-1:0] periodCfg,
  output logic                cnvOut,
  output logic                sckOut,
  output sarStrobe_t          strobe
);

  localparam int CNT_MAX = (CNV_HOLD > EN_WAIT) ? CNV_HOLD : EN_WAIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SUB_W   = $clog2(SCK_PERIOD);
  localparam int BIT_W   = $clog2(BITS);
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

  sarState_e            state;
  logic [CNT_W-1:0]     phaseCnt;
  logic [SUB_W-1:0]     subCnt;
  logic [BIT_W-1:0]     bitCnt;
  logic [PERIOD_W-1:0]  gapCnt;
  logic [PERIOD_W-1:0]  effPeriod;
  logic                 go;
  logic                 riseSlot;
  logic                 fallSlot;
  logic                 lastBit;

  assign effPeriod = (periodCfg < MIN_P) ? MIN_P : periodCfg;
  assign go        = (state == ST_IDLE) && (startReq || runEn) && (gapCnt == '0);
  assign riseSlot  = (state == ST_SHIFT) && (subCnt == SUB_W'(SCK_PERIOD - 2));
  assign fallSlot  = (state == ST_SHIFT) && (subCnt == SUB_W'(SCK_PERIOD - 1));
  assign lastBit   = (bitCnt == BIT_W'(BITS - 1));

  always_comb begin
    strobe.clear   = go;
    strobe.capture = riseSlot;
    strobe.emit    = fallSlot && lastBit;
  end

  // Start-to-start spacing guard.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (go) begin
      gapCnt <= effPeriod - PERIOD_W'(1);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - PERIOD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      subCnt   <= '0;
      bitCnt   <= '0;
      cnvOut   <= 1'b0;
      sckOut   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state    <= ST_CONV;
            phaseCnt <= '0;
            cnvOut   <= 1'b1;
          end
        end
        ST_CONV: begin
          if (phaseCnt == CNT_W'(CNV_HOLD - 1)) begin
            state    <= ST_WAIT;
            phaseCnt <= '0;
            cnvOut   <= 1'b0;
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (phaseCnt == CNT_W'(EN_WAIT - 1)) begin
            state  <= ST_SHIFT;
            subCnt <= '0;
            bitCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (riseSlot) begin
            sckOut <= 1'b1;
          end
          if (fallSlot) begin
            sckOut <= 1'b0;
            subCnt <= '0;
            bitCnt <= bitCnt + BIT_W'(1);
            if (lastBit) begin
              state <= ST_IDLE;
            end
          end else begin
            subCnt <= subCnt + SUB_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_readout_dp.sv
module sar_readout_dp
  import sar_readout_pkg::*;
#(
  parameter int BITS = 18
) (
  input  logic            clk,
  input  logic            rstN,
  input  sarStrobe_t      strobe,
  input  logic            sdoIn,
  output logic [BITS-1:0] sample,
  output logic            sampleValid
);

  logic [BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      if (strobe.clear) begin
        shiftReg <= '0;
      end else if (strobe.capture) begin
        shiftReg <= {shiftReg[BITS-2:0], sdoIn};
      end
      sampleValid <= strobe.emit;
      if (strobe.emit) begin
        sample <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_readout_pkg::*;
#(
  parameter bit SLOW_PART   = 1'b0,
  parameter int BITS        = 18,
  parameter int CONV_FAST   = 150,
  parameter int CONV_SLOW   = 950,
  parameter int PERIOD_FAST = 200,
  parameter int PERIOD_SLOW = 1000,
  parameter int PULSE_MIN   = 50,
  parameter int EN_WAIT     = 4,
  parameter int SCK_PERIOD  = 4,
  parameter int PERIOD_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                runEn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic                adcSdo,
  output logic                adcCnv,
  output logic                adcSck,
  output logic [BITS-1:0]     sample,
  output logic                sampleValid
);

  localparam int CONV_CYC   = SLOW_PART ? CONV_SLOW : CONV_FAST;
  localparam int CNV_HOLD   = (CONV_CYC > PULSE_MIN) ? CONV_CYC : PULSE_MIN;
  localparam int MIN_PERIOD = SLOW_PART ? PERIOD_SLOW : PERIOD_FAST;

  sarStrobe_t strobe;

  sar_readout_ctrl #(
    .BITS      (BITS),
    .CNV_HOLD  (CNV_HOLD),
    .EN_WAIT   (EN_WAIT),
    .SCK_PERIOD(SCK_PERIOD),
    .MIN_PERIOD(MIN_PERIOD),
    .PERIOD_W  (PERIOD_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .runEn    (runEn),
    .periodCfg(periodCfg),
    .cnvOut   (adcCnv),
    .sckOut   (adcSck),
    .strobe   (strobe)
  );

  sar_readout_dp #(
    .BITS(BITS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sdoIn      (adcSdo),
    .sample     (sample),
    .sampleValid(sampleValid)
  );

endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int BITS       = 18,
  parameter int EN_WAIT    = 4,
  parameter int MIN_PERIOD = 200
) (
  input logic clk,
  input logic rstN,
  input logic cnv,
  input logic sck,
  input logic valid
);

  logic        prevCnv;
  logic        prevSck;
  logic        seenRise;
  logic [31:0] sinceRise;
  logic [31:0] sinceFall;
  logic [31:0] pulseCnt;
  logic        cnvRise;
  logic        cnvFall;
  logic        sckRise;

  assign cnvRise = cnv && !prevCnv;
  assign cnvFall = !cnv && prevCnv;
  assign sckRise = sck && !prevSck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCnv   <= 1'b0;
      prevSck   <= 1'b0;
      seenRise  <= 1'b0;
      sinceRise <= '0;
      sinceFall <= '0;
      pulseCnt  <= '0;
    end else begin
      prevCnv <= cnv;
      prevSck <= sck;
      if (cnvRise) begin
        seenRise  <= 1'b1;
        sinceRise <= 32'd1;
        pulseCnt  <= '0;
      end else begin
        if (sinceRise != 32'hFFFF_FFFF) sinceRise <= sinceRise + 32'd1;
        if (sckRise) pulseCnt <= pulseCnt + 32'd1;
      end
      if (cnvFall) begin
        sinceFall <= 32'd1;
      end else if (sinceFall != 32'hFFFF_FFFF) begin
        sinceFall <= sinceFall + 32'd1;
      end
    end
  end

  // R5
  a_r5_sck_quiet_in_conv: assert property (@(posedge clk) disable iff (!rstN)
    cnv |-> !sck);

  // R4
  a_r4_sck_one_cycle_high: assert property (@(posedge clk) disable iff (!rstN)
    sck |=> !sck);

  // R7
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R3
  a_r3_first_edge_wait: assert property (@(posedge clk) disable iff (!rstN)
    (sckRise && pulseCnt == 32'd0) |-> (sinceFall >= 32'(EN_WAIT)));

  // R4
  a_r4_pulse_total: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (pulseCnt == 32'(BITS)));

  // R8
  a_r8_start_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (cnvRise && seenRise) |-> (sinceRise >= 32'(MIN_PERIOD)));

endmodule

bind sar_readout sar_readout_chk #(
  .BITS      (BITS),
  .EN_WAIT   (EN_WAIT),
  .MIN_PERIOD(MIN_PERIOD)
) uChk (
  .clk  (clk),
  .rstN (rstN),
  .cnv  (adcCnv),
  .sck  (adcSck),
  .valid(sampleValid)
);

// File: tb/sar_readout_test.sv
`timescale 1ns/1ps
module sar_readout_test;

  localparam int BITS       = 18;
  localparam int CONV_FAST  = 20;
  localparam int PERIOD_FST = 120;
  localparam int PULSE_MIN  = 12;
  localparam int EN_WAIT    = 4;
  localparam int SCKP       = 4;
  localparam int PERIOD_W   = 16;
  localparam int HOLD       = (CONV_FAST > PULSE_MIN) ? CONV_FAST : PULSE_MIN;
  localparam int DONE_T     = HOLD + EN_WAIT + BITS * SCKP;
  localparam int XFER_LEN   = DONE_T + 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startReq = 1'b0;
  logic                runEn = 1'b0;
  logic [PERIOD_W-1:0] periodCfg = '0;
  logic                adcSdo = 1'b1;
  logic                adcCnv;
  logic                adcSck;
  logic [BITS-1:0]     sample;
  logic                sampleValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sar_readout #(
    .SLOW_PART  (1'b0),
    .BITS       (BITS),
    .CONV_FAST  (CONV_FAST),
    .PERIOD_FAST(PERIOD_FST),
    .PULSE_MIN  (PULSE_MIN),
    .EN_WAIT    (EN_WAIT),
    .SCK_PERIOD (SCKP),
    .PERIOD_W   (PERIOD_W)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .runEn      (runEn),
    .periodCfg  (periodCfg),
    .adcSdo     (adcSdo),
    .adcCnv     (adcCnv),
    .adcSck     (adcSck),
    .sample     (sample),
    .sampleValid(sampleValid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int effOf(input int cfg);
    return (cfg < PERIOD_FST) ? PERIOD_FST : cfg;
  endfunction

  function automatic logic [BITS-1:0] wordFor(input int idx);
    case (idx)
      0: return 18'h3FFFF;
      1: return 18'h00000;
      2: return 18'h20000;
      3: return 18'h00001;
      4: return 18'h2AAAA;
      5: return 18'h15555;
      default: return BITS'((idx * 40503 + 12345) ^ (idx << 7));
    endcase
  endfunction

  // Converter model: word chosen at convert rise, bits appear after the
  // convert falling edge and after each serial clock falling edge.
  logic [BITS-1:0] curWord = '0;
  int              bitPtr = -1;
  int              convIdx = 0;
  logic [BITS-1:0] expQ[$];

  always @(posedge adcCnv) begin
    adcSdo  = 1'b1;
    bitPtr  = -1;
    curWord = wordFor(convIdx);
    expQ.push_back(curWord);
    convIdx++;
  end

  always @(negedge adcCnv) begin
    if (rstN) begin
      #35;
      adcSdo = curWord[BITS-1];
      bitPtr = BITS - 2;
    end
  end

  always @(negedge adcSck) begin
    #18;
    if (bitPtr >= 0) begin
      adcSdo = curWord[bitPtr];
      bitPtr = bitPtr - 1;
    end else begin
      adcSdo = ~adcSdo;  // line released: junk
    end
  end

  // Behavioural reference model, advanced on each rising edge.
  bit mActive = 0;
  bit mDone = 0;
  int mT = 0;
  int mGap = 0;
  int mEffCur = 0;
  int mEffPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mDone = 0; mT = 0; mGap = 0;
    end else begin
      mDone = 0;
      if (mActive) begin
        mT++;
        if (mT == DONE_T) begin
          mActive = 0;
          mDone = 1;
        end
        if (mGap > 0) mGap--;
      end else if ((startReq || runEn) && mGap == 0) begin
        mActive  = 1;
        mT       = 0;
        mEffPrev = mEffCur;
        mEffCur  = effOf(int'(periodCfg));
        mGap     = mEffCur - 1;
      end else if (mGap > 0) begin
        mGap--;
      end
    end
  end

  // Per-cycle comparison, mid-cycle.
  bit prevCnvSeen = 0;
  int lastRise = -1;
  bit runHeld = 0;

  always @(negedge clk) begin
    bit eCnv, eSck;
    cyc++;
    if (rstN) begin
      eCnv = mActive && (mT < HOLD);
      eSck = mActive && (mT >= HOLD + EN_WAIT) && (((mT - HOLD - EN_WAIT) % SCKP) == SCKP - 1);
      chk(adcCnv == eCnv, "R2,R8 convert line", int'(adcCnv), int'(eCnv));
      chk(adcSck == eSck, "R3,R4,R5 serial clock", int'(adcSck), int'(eSck));
      chk(sampleValid == mDone, "R7 valid pulse", int'(sampleValid), int'(mDone));
      if (sampleValid) begin
        if (expQ.size() > 0) begin
          logic [BITS-1:0] e;
          e = expQ.pop_front();
          chk(sample == e, "R6 sample word", int'(sample), int'(e));
        end else begin
          chk(1'b0, "R6 unexpected sample", int'(sample), 0);
        end
      end
      if (adcCnv && !prevCnvSeen) begin
        if (lastRise >= 0) begin
          int sp, want;
          sp = cyc - lastRise;
          want = (mEffPrev > XFER_LEN) ? mEffPrev : XFER_LEN;
          chk(sp >= mEffPrev, "R8 start spacing floor", sp, mEffPrev);
          if (runHeld) chk(sp == want, "R9 free-run spacing", sp, want);
        end
        lastRise = cyc;
        runHeld = 1;
      end
      if (!runEn) runHeld = 0;
      prevCnvSeen = adcCnv;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitValid();
    do @(negedge clk); while (!sampleValid);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finishRun();
  end

  initial begin
    waitCycles(4);
    // R1: reset state
    chk(adcCnv == 1'b0, "R1 convert low in reset", int'(adcCnv), 0);
    chk(adcSck == 1'b0, "R1 clock low in reset", int'(adcSck), 0);
    chk(sampleValid == 1'b0, "R1 valid low in reset", int'(sampleValid), 0);
    chk(sample == '0, "R1 sample zero in reset", int'(sample), 0);
    @(negedge clk) rstN = 1'b1;
    waitCycles(1);
    chk(adcCnv == 1'b0 && adcSck == 1'b0, "R1 idle after reset", int'({adcCnv, adcSck}), 0);

    // single sample; a request mid-conversion must be ignored (R2)
    waitCycles(3);
    pulseStart();
    waitCycles(30);
    pulseStart();
    waitValid();
    // request inside the spacing window is ignored (R8)
    waitCycles(2);
    pulseStart();
    waitCycles(5);
    chk(adcCnv == 1'b0, "R8 early request ignored", int'(adcCnv), 0);
    waitCycles(40);
    pulseStart();
    waitValid();
    waitCycles(150);

    // free-run at floor, then host periods (R9)
    @(negedge clk) begin periodCfg = 16'd0; runEn = 1'b1; end
    repeat (6) waitValid();
    @(negedge clk) periodCfg = 16'd200;
    repeat (4) waitValid();
    @(negedge clk) periodCfg = 16'd150;
    repeat (4) waitValid();
    @(negedge clk) runEn = 1'b0;
    waitCycles(300);
    chk(adcCnv == 1'b0 && adcSck == 1'b0, "R5 idle after run", int'({adcCnv, adcSck}), 0);
    chk(expQ.size() == 0, "R6 all words delivered", expQ.size(), 0);
    finishRun();
  end

endmodule